// File: doc/BRIEF.md
# Block Floating Point Pass Scaler

This block keeps the data of a multi-pass, in-place FFT inside a fixed word width. Each pass handles a block of complex integer pairs, and all pairs in the block share a single signed exponent. While a pass writes its results back to memory, the scaler measures how far each real and imaginary word has grown beyond the nominal width `W`, and it keeps the largest growth seen during that pass.

When the next pass begins, that peak becomes a single shift amount. The shift applies to every word read back during that pass. The same amount is subtracted from the block exponent. The true magnitude of a result is therefore `out * 2^(-exp)`.

The engine writes words that are `W+G` bits wide, where `G` is the number of guard bits. The memory stores words of the same width. The scaler delivers `W`-bit words to the engine on the read side. At the end of a block, the exponent is presented with a one-cycle valid strobe.

Top module: `bfp_pass_scaler`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `exp_valid`, `cur_shift` and `exp_o` are all 0.
- R2: The growth of a written word is the smallest g in 0..G for which the word lies in [-2^(W+g-1), 2^(W+g-1)). The pass peak is the largest growth over both the real and the imaginary parts of all counted writes. A peak seen only on the imaginary part counts the same as one seen on the real part.
- R3: On a `pass_start` cycle, `cur_shift` takes the peak of the previous pass, starting from the next cycle. It then holds that value until the next `pass_start` or `blk_start`.
- R4: `exp_o` is a signed value. On each `pass_start` it decreases by the peak that `cur_shift` takes, and at all other times it holds.
- R5: A read sample with `rd_valid` appears one cycle later, with `out_valid` set. Its value is floor(rd/2^s), truncated to W bits, where s is the shift of the current pass. Division rounds toward negative infinity.
- R6: The peak restarts on every `pass_start`, so a pass with no growth gives a shift of 0. A write in the `pass_start` cycle counts toward the new pass. A read in that cycle already uses the new shift.
- R7: A write with `wr_valid` that arrives after `pass_end` and before the next `pass_start` has no effect on the next shift.
- R8: `blk_start` clears the exponent, the shift and the peak. A write in the same cycle is not counted.
- R9: `exp_valid` pulses for one cycle, one cycle after `blk_end`. During that cycle `exp_o` carries the block exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Start of a new block; clears exponent, shift and peak |
| blk_end | input | 1 | End of the block; triggers the exponent strobe |
| pass_start | input | 1 | First cycle of a pass; commits the peak as the shift |
| pass_end | input | 1 | Last cycle in which writes count toward the pass peak |
| wr_valid | input | 1 | Engine result word pair valid |
| wr_re | input | W+G | Engine result, real part (signed) |
| wr_im | input | W+G | Engine result, imaginary part (signed) |
| rd_valid | input | 1 | Memory read word pair valid |
| rd_re | input | W+G | Memory read data, real part (signed) |
| rd_im | input | W+G | Memory read data, imaginary part (signed) |
| out_valid | output | 1 | Scaled pair valid |
| out_re | output | W | Scaled real part |
| out_im | output | W | Scaled imaginary part |
| cur_shift | output | clog2(G+1) | Shift applied during the current pass |
| exp_o | output | clog2(MAX_PASSES*G)+1 | Signed block exponent |
| exp_valid | output | 1 | Exponent strobe at block end |

## Verification
A `pass_start` can arrive in the same cycle as a write, which must seed the new peak, and as a read, which must already use the new shift. The bench provokes this by raising `pass_start`, `wr_valid` and `rd_valid` together. It judges the read by its scaled value one cycle later, and it judges the write by the shift committed at the following `pass_start`. A write after `pass_end` and a write coinciding with `blk_start` are also judged by the following shift.

// File: rtl/bfp_pass_scaler.sv
module bfp_pass_scaler #(
  parameter int W = 16,
  parameter int G = 2,
  parameter int MAX_PASSES = 8,
  localparam int WI = W + G,
  localparam int SW = $clog2(G + 1),
  localparam int EW = $clog2(MAX_PASSES * G) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blk_start,
  input  logic                 blk_end,
  input  logic                 pass_start,
  input  logic                 pass_end,
  input  logic                 wr_valid,
  input  logic signed [WI-1:0] wr_re,
  input  logic signed [WI-1:0] wr_im,
  input  logic                 rd_valid,
  input  logic signed [WI-1:0] rd_re,
  input  logic signed [WI-1:0] rd_im,
  output logic                 out_valid,
  output logic signed [W-1:0]  out_re,
  output logic signed [W-1:0]  out_im,
  output logic [SW-1:0]        cur_shift,
  output logic signed [EW-1:0] exp_o,
  output logic                 exp_valid
);

  function automatic logic [SW-1:0] grow(input logic signed [WI-1:0] x);
    logic signed [WI-1:0] t;
    grow = SW'(G);
    for (int g = G; g >= 0; g--) begin
      t = x >>> (W + g - 1);
      if (t == '0 || t == '1) grow = SW'(g);
    end
  endfunction

  logic [SW-1:0] peak_q, g_re, g_im, gw, shift_eff;
  logic          open_q, take;

  assign g_re      = grow(wr_re);
  assign g_im      = grow(wr_im);
  assign gw        = (g_re > g_im) ? g_re : g_im;
  assign take      = wr_valid && (open_q || pass_start) && !blk_start;
  assign shift_eff = pass_start ? peak_q : cur_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      exp_valid <= 1'b0;
      exp_o     <= '0;
      cur_shift <= '0;
      peak_q    <= '0;
      open_q    <= 1'b0;
    end else begin
      out_valid <= rd_valid;
      exp_valid <= blk_end;
      if (rd_valid) begin
        out_re <= W'(rd_re >>> shift_eff);
        out_im <= W'(rd_im >>> shift_eff);
      end
      if (blk_start) begin
        exp_o     <= '0;
        cur_shift <= '0;
        peak_q    <= '0;
        open_q    <= 1'b0;
      end else begin
        if (pass_start) begin
          exp_o     <= exp_o - EW'(peak_q);
          cur_shift <= peak_q;
          peak_q    <= take ? gw : '0;
          open_q    <= 1'b1;
        end else if (take && gw > peak_q) begin
          peak_q <= gw;
        end
        if (pass_end) open_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bfp_pass_scaler_chk.sv
module bfp_pass_scaler_chk #(
  parameter int G  = 2,
  parameter int SW = 2,
  parameter int EW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_start,
  input logic          blk_end,
  input logic          pass_start,
  input logic          rd_valid,
  input logic          out_valid,
  input logic [SW-1:0] cur_shift,
  input logic [EW-1:0] exp_o,
  input logic          exp_valid
);

  p_shift_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_shift <= SW'(G));

  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_start && !blk_start) |=> $stable(cur_shift));

  p_exp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_start && !blk_start) |=> $stable(exp_o));

  p_exp_nonpos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(exp_o) <= 0);

  p_exp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !blk_start) |=> (EW'($past(exp_o) - exp_o) == EW'(cur_shift)));

  p_blk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (exp_o == '0 && cur_shift == '0));

  p_out_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  p_out_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid);

  p_exp_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> exp_valid);

  p_exp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_end |=> !exp_valid);

endmodule

bind bfp_pass_scaler bfp_pass_scaler_chk #(.G(G), .SW(SW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_end(blk_end),
  .pass_start(pass_start), .rd_valid(rd_valid), .out_valid(out_valid),
  .cur_shift(cur_shift), .exp_o(exp_o), .exp_valid(exp_valid)
);

// File: tb/bfp_pass_scaler_bench.sv
module bfp_pass_scaler_bench;
  localparam int W = 16, G = 2, MP = 8;
  localparam int WI = W + G, SW = $clog2(G + 1), EW = $clog2(MP * G) + 1;

  logic clk = 0, rst_n = 0;
  logic blk_start = 0, blk_end = 0, pass_start = 0, pass_end = 0;
  logic wr_valid = 0, rd_valid = 0;
  logic signed [WI-1:0] wr_re = 0, wr_im = 0, rd_re = 0, rd_im = 0;
  logic out_valid, exp_valid;
  logic signed [W-1:0] out_re, out_im;
  logic [SW-1:0] cur_shift;
  logic signed [EW-1:0] exp_o;

  int n_tests = 0, n_fail = 0;
  longint ref_exp = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bfp_pass_scaler #(.W(W), .G(G), .MAX_PASSES(MP)) u_bfp_pass_scaler (.*);

  task automatic chk(string req, longint act, longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int gref(longint x);
    for (int g = 0; g <= G; g++)
      if (x >= -(64'sd1 <<< (W + g - 1)) && x < (64'sd1 <<< (W + g - 1))) return g;
    return G;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    blk_start = 0; blk_end = 0; pass_start = 0; pass_end = 0;
    wr_valid = 0; rd_valid = 0;
  endtask

  task automatic wr(longint re, longint im);
    wr_valid = 1; wr_re = WI'(re); wr_im = WI'(im);
    tick();
  endtask

  task automatic rd(string req, longint re, longint im, int s);
    rd_valid = 1; rd_re = WI'(re); rd_im = WI'(im);
    tick();
    chk({req, " valid"}, out_valid, 1);
    chk({req, " re"}, out_re, re >>> s);
    chk({req, " im"}, out_im, im >>> s);
  endtask

  task automatic new_pass(string req, int peak);
    pass_start = 1;
    tick();
    ref_exp -= peak;
    chk({req, " shift"}, cur_shift, peak);
    chk({req, " exp"}, exp_o, ref_exp);
  endtask

  task automatic new_block();
    blk_start = 1;
    tick();
    ref_exp = 0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 exp_valid", exp_valid, 0);
    chk("R1 shift", cur_shift, 0);
    chk("R1 exp", exp_o, 0);
  endtask

  task automatic t_basic();
    new_block();
    new_pass("R3 first pass", 0);
    rd("R5 unscaled", 1234, -1234, 0);
    wr(40000, 5);
    wr(-100, 200);
    pass_end = 1; tick();
    new_pass("R3 growth one", 1);
    rd("R5 floor neg", -3, 3, 1);
    rd("R5 wide", 65535, -65536, 1);
  endtask

  task automatic t_imag_peak();
    wr(10, -100000);
    wr(-40000, 0);
    pass_end = 1; tick();
    new_pass("R2 imag peak", 2);
    rd("R5 shift two", -5, 131071, 2);
  endtask

  task automatic t_late_write();
    wr(40000, 0);
    pass_end = 1; tick();
    wr(-131072, 131071);
    new_pass("R7 late write", 1);
    chk("R4 exp sum", exp_o, -4);
  endtask

  task automatic t_same_cycle();
    pass_end = 1; tick();
    pass_start = 1;
    wr_valid = 1; wr_re = WI'(-50000); wr_im = 0;
    rd_valid = 1; rd_re = WI'(-7); rd_im = WI'(9);
    tick();
    ref_exp -= 0;
    chk("R6 shift", cur_shift, 0);
    chk("R6 read uses new shift re", out_re, -7);
    chk("R6 read uses new shift im", out_im, 9);
    pass_end = 1; tick();
    new_pass("R6 seeded peak", 1);
  endtask

  task automatic t_restart();
    wr(100, -100);
    pass_end = 1; tick();
    new_pass("R6 restart", 0);
    rd("R6 no shift", -32768, 32767, 0);
  endtask

  task automatic t_blk_end();
    blk_end = 1; tick();
    chk("R9 exp_valid", exp_valid, 1);
    chk("R9 exp", exp_o, ref_exp);
    tick();
    chk("R9 pulse", exp_valid, 0);
  endtask

  task automatic t_blk_clear();
    new_pass("R8 prep", 0);
    wr(131071, 0);
    blk_start = 1;
    wr_valid = 1; wr_re = WI'(-131072); wr_im = 0;
    tick();
    ref_exp = 0;
    chk("R8 exp", exp_o, 0);
    chk("R8 shift", cur_shift, 0);
    new_pass("R8 peak cleared", 0);
  endtask

  task automatic t_random();
    for (int b = 0; b < 3; b++) begin
      int pk;
      new_block();
      new_pass("R5 rnd first", 0);
      pk = 0;
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 6; k++) begin
          int g;
          longint lim, a, c;
          g = int'($urandom % (G + 1));
          lim = 64'sd1 <<< (W + g - 1);
          a = longint'($urandom) % (2 * lim) - lim;
          c = longint'($urandom) % (2 * lim) - lim;
          if (gref(a) > pk) pk = gref(a);
          if (gref(c) > pk) pk = gref(c);
          wr(a, c);
        end
        pass_end = 1; tick();
        new_pass("R2 rnd pass", pk);
        for (int k = 0; k < 4; k++) begin
          longint lim, a, c;
          lim = 64'sd1 <<< (W + pk - 1);
          a = longint'($urandom) % (2 * lim) - lim;
          c = longint'($urandom) % (2 * lim) - lim;
          rd("R5 rnd read", a, c, pk);
        end
        pk = 0;
      end
      blk_end = 1; tick();
      chk("R9 rnd exp", exp_o, ref_exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_imag_peak();
    t_late_write();
    t_same_cycle();
    t_restart();
    t_blk_end();
    t_blk_clear();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule